// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides two unsigned integers of parameterised width `WIDTH` over several clock cycles and produces one quotient bit in each cycle. It holds a single register of 2·`WIDTH`+1 bits. The upper part of this register is the partial remainder. The lower half fills with quotient bits as the operation proceeds. One `WIDTH`-bit register keeps the divisor.

The block accepts a new operation on a one-cycle `start` pulse while it is idle. It then runs exactly `WIDTH` iterations. In each iteration it compares the partial remainder against the divisor, subtracts only when the divisor fits, and shifts one new quotient bit in at the bottom. When the last iteration completes, `done` pulses for one cycle. The quotient is read from the low half of the register. The remainder is the upper part moved down by one place.

A zero divisor ends the operation at once and sets a flag. The operands and results are plain control and data pins with no handshake. `start` is the request. `busy` shows that the block is occupied. The results stay put after `done` until the next accepted start.

Top module: `restoring_divider`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `busy`, `done` and `div_by_zero` are 0, and `quotient` and `remainder` are 0.
- R2: A `start` seen at a rising edge while `busy` is 0 is accepted. If `divisor` is non-zero, `busy` is 1 from that edge on.
- R3: A non-zero-divisor operation takes exactly `WIDTH` iteration cycles. Counting the start edge as the first, `busy` falls and `done` rises at the (`WIDTH`+1)-th rising edge. `busy` and `done` are never 1 together.
- R4: At `done`, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor. Both are taken from the operands captured at the accepted start. This holds for every operand value, including full-scale dividends and divisors.
- R5: A zero divisor gives `done` = 1 and `div_by_zero` = 1 in the cycle after the start edge, with no busy cycle. `quotient` is then all ones and `remainder` equals the dividend.
- R6: A `start` seen while `busy` is 1 is ignored. The running operation finishes at its original time with the result of its own operands.
- R7: `done` is a one-cycle pulse. After it, `quotient`, `remainder` and `div_by_zero` hold their values until the next accepted start.
- R8: A `start` in the cycle in which `done` is 1 is accepted, and that new operation completes normally.
- R9: An accepted start with a non-zero divisor clears `div_by_zero`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a division, taken when idle |
| dividend | input | WIDTH | Unsigned numerator, sampled on an accepted start |
| divisor | input | WIDTH | Unsigned denominator, sampled on an accepted start |
| busy | output | 1 | Iterations are in progress |
| done | output | 1 | One-cycle pulse: result is ready |
| quotient | output | WIDTH | Integer quotient |
| remainder | output | WIDTH | Integer remainder |
| div_by_zero | output | 1 | Last accepted operation had a zero divisor |

## Verification
Completion and acceptance can fall in the same cycle. While `done` is high, `busy` is already low, so a fresh `start` is taken at the same edge that would otherwise let the finished result sit idle. The bench drives such a start during the `done` cycle. It first confirms that the old quotient and remainder are visible in that cycle, then confirms that the new operation finishes `WIDTH` cycles later with its own result. A zero-divisor start also makes `done` follow acceptance immediately. The full sweep runs such cases back to back with normal operations, and the bench judges both the timing and the values.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;
endpackage

// File: rtl/rdiv_step.sv
// One restoring iteration: trial subtract of the divisor from the upper part,
// keep the difference only when no borrow occurs, shift left, insert the bit.
module rdiv_step #(
  parameter int WIDTH = 32
) (
  input  logic [2*WIDTH:0] acc_i,
  input  logic [WIDTH-1:0] dvs_i,
  output logic [2*WIDTH:0] acc_o,
  output logic             qbit_o
);
  localparam int HW = WIDTH + 1;

  logic [HW-1:0]    hi;
  logic [WIDTH-1:0] lo;
  logic [HW:0]      diff;
  logic [HW-1:0]    kept;

  always_comb begin
    hi     = acc_i[2*WIDTH:WIDTH];
    lo     = acc_i[WIDTH-1:0];
    diff   = {1'b0, hi} - {2'b00, dvs_i};
    qbit_o = ~diff[HW];
    kept   = qbit_o ? diff[HW-1:0] : hi;
    // kept < divisor, so its top bit is zero and dropping it is the shift
    acc_o  = {kept[WIDTH-1:0], lo, qbit_o};
  end
endmodule

// File: rtl/rdiv_count.sv
// Iteration counter: loaded with WIDTH-1, flags the final iteration.
module rdiv_count #(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic en,
  output logic last
);
  localparam int CW = $clog2(WIDTH) + 1;
  localparam logic [CW-1:0] START_VAL = CW'(WIDTH - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= START_VAL;
    else if (en && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);

  a_r3_load_not_last: assert property (@(posedge clk) disable iff (rst)
    (load && WIDTH > 1) |=> !last);
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             div_by_zero
);
  import rdiv_pkg::*;

  localparam int AW = 2 * WIDTH + 1;

  phase_t           phase;
  logic [AW-1:0]    acc;
  logic [AW-1:0]    acc_next;
  logic [WIDTH-1:0] dvs_q;
  logic             done_q;
  logic             dbz_q;
  logic             qbit;
  logic             last;
  logic             accept;
  logic             zero_dvs;

  assign accept   = start && (phase == PH_IDLE);
  assign zero_dvs = (divisor == '0);

  rdiv_step #(.WIDTH(WIDTH)) u_step (
    .acc_i  (acc),
    .dvs_i  (dvs_q),
    .acc_o  (acc_next),
    .qbit_o (qbit)
  );

  rdiv_count #(.WIDTH(WIDTH)) u_count (
    .clk  (clk),
    .rst  (rst),
    .load (accept && !zero_dvs),
    .en   (phase == PH_RUN),
    .last (last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      acc    <= '0;
      dvs_q  <= '0;
      done_q <= 1'b0;
      dbz_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        dvs_q <= divisor;
        dbz_q <= zero_dvs;
        if (zero_dvs) begin
          acc    <= {dividend, 1'b0, {WIDTH{1'b1}}};
          done_q <= 1'b1;
        end else begin
          // dividend loaded with the upper part cleared, already shifted once
          acc   <= {{WIDTH{1'b0}}, dividend, 1'b0};
          phase <= PH_RUN;
        end
      end else if (phase == PH_RUN) begin
        acc <= acc_next;
        if (last) begin
          phase  <= PH_IDLE;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy        = (phase == PH_RUN);
  assign done        = done_q;
  assign div_by_zero = dbz_q;
  assign quotient    = acc[WIDTH-1:0];
  assign remainder   = acc[AW-1:WIDTH+1];

  // R2: an idle start with a usable divisor makes the block busy
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor != '0) |=> busy);

  // R3: busy and done never overlap; leaving busy coincides with done
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  a_r3_finish_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R4: the partial remainder stays below twice the divisor every iteration
  a_r4_partial_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (acc[AW-1:WIDTH] < {dvs_q, 1'b0}));

  // R5: zero divisor completes immediately with the flag
  a_r5_zero_quick: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && divisor == '0) |=> (done && div_by_zero && !busy));

  // R6: the captured divisor cannot change while iterating
  a_r6_divisor_held: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(dvs_q));

  // R7: outputs hold while idle without a start; done is a pulse
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done || div_by_zero));
endmodule

// File: tb/sim_restoring_divider.sv
`timescale 1ns/1ps
module sim_restoring_divider;
  localparam int W = 6;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  restoring_divider #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .div_by_zero(div_by_zero)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic launch(input int a, input int b);
    @(negedge clk);
    start = 1'b1; dividend = W'(a); divisor = W'(b);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < W + 4) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic judge(input int a, input int b, input string req);
    int eq, er;
    eq = (b == 0) ? MAXV : a / b;
    er = (b == 0) ? a : a % b;
    check(done == 1'b1, {req, " done"}, done, 1);
    check(quotient == W'(eq), {req, " quotient"}, quotient, eq);
    check(remainder == W'(er), {req, " remainder"}, remainder, er);
    check(div_by_zero == (b == 0), {req, " div_by_zero"}, div_by_zero, b == 0);
    if (b != 0)
      check((int'(quotient) * b + int'(remainder) == a) && (int'(remainder) < b),
            {req, " identity"}, remainder, er);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0 && done == 0 && div_by_zero == 0, "R1 flags", {busy, done, div_by_zero}, 0);
    check(quotient == 0 && remainder == 0, "R1 results", {quotient, remainder}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0 && done == 0 && quotient == 0, "R1 after release", {busy, done}, 0);

    // R2 R3 R4 R5: exhaustive sweep over all operand pairs
    for (int a = 0; a <= MAXV; a++) begin
      for (int b = 0; b <= MAXV; b++) begin
        launch(a, b);
        if (b != 0) check(busy == 1'b1, "R2 busy after start", busy, 1);
        wait_done(cyc);
        check(cyc == ((b == 0) ? 0 : W), (b == 0) ? "R5 latency" : "R3 latency", cyc, (b == 0) ? 0 : W);
        check(!busy, "R3 busy low at done", busy, 0);
        judge(a, b, (b == 0) ? "R5" : "R4");
      end
    end

    // R7: done is a pulse and results hold
    launch(MAXV, 5);
    wait_done(cyc);
    judge(MAXV, 5, "R7 base");
    repeat (3) begin
      @(negedge clk);
      check(done == 0, "R7 done pulse", done, 0);
      check(quotient == W'(MAXV / 5) && remainder == W'(MAXV % 5), "R7 hold", quotient, MAXV / 5);
    end

    // R6: start while busy is ignored
    launch(45, 7);
    @(negedge clk);
    start = 1'b1; dividend = W'(63); divisor = W'(1);
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    check(cyc == W - 2, "R6 timing kept", cyc, W - 2);
    judge(45, 7, "R6");

    // R8: start in the done cycle
    launch(50, 3);
    wait_done(cyc);
    judge(50, 3, "R8 old result in done cycle");
    start = 1'b1; dividend = W'(61); divisor = W'(MAXV);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8 accepted", busy, 1);
    wait_done(cyc);
    check(cyc == W, "R8 latency", cyc, W);
    judge(61, MAXV, "R8 new");

    // R9: flag cleared by a later non-zero divisor
    launch(9, 0);
    wait_done(cyc);
    check(div_by_zero == 1, "R9 flag set", div_by_zero, 1);
    launch(9, 4);
    check(div_by_zero == 0, "R9 flag cleared", div_by_zero, 0);
    wait_done(cyc);
    judge(9, 4, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule